// File: doc/BRIEF.md
# Sector-Read Task-File Register Target

This block is a memory-mapped register target that looks like a small disk controller to a host. The host writes a 29-bit logical block address one byte field at a time. It then writes a sector count and a command code. After a read command the block streams bytes out of an internal byte store. The host pulls them through a 16-bit word port or an 8-bit byte port. A remaining-length counter tracks the transfer. A status register shows whether data is waiting and whether the last command was rejected.

The byte store is an internal RAM of `STORE_BYTES` bytes, which must be a power of two and at least 1024. The host fills it through a separate fill port before use. Byte addresses are taken modulo the store size. Every bus access completes in one cycle. Read data appears on `busRdData` one clock after the access and holds there until the next read access.

Top module: `sectorPortTarget`

## Requirements
- R1: Bus offsets are decoded as follows: 0x20 word data, 0x21 byte data, 0x23 error (read) and feature (write), 0x25 sector count, 0x27 address bits 7:0, 0x29 bits 15:8, 0x2B bits 23:16, 0x2D bits 28:24 (taken from data bits 4:0), and 0x2F status (read) and command (write).
- R2: Each address write replaces only its own field of the block address. A read transfer starts at byte (address × 512) modulo `STORE_BYTES`.
- R3: Writing the sector count n sets the remaining length to n × 512 bytes and cancels any transfer in progress.
- R4: Command 0x20 with a nonzero remaining length starts a transfer and sets data request. With zero remaining it starts nothing. A data-port read never sees a nonzero remaining length become negative.
- R5: A word-port read during a transfer returns the byte at the pointer in bits 7:0 and the next byte in bits 15:8. It advances the pointer and reduces the remaining length by 2. When only 1 byte remains, it returns that byte in bits 7:0 with zero in bits 15:8, and the length becomes 0.
- R6: A byte-port read during a transfer returns the next byte in bits 7:0 with bits 15:8 zero, and reduces the remaining length by 1.
- R7: When the remaining length reaches zero through data reads, data request clears and all four address fields clear to zero.
- R8: A data-port read with no transfer active returns zero and leaves the remaining length unchanged.
- R9: The status byte reads busy in bit 7 (always 0), data request in bit 3 and error in bit 0. All other bits are zero.
- R10: Commands 0x30, 0xEC and 0xEF are accepted without a data transfer. They end any active transfer and clear both the error bit and the error register to 0x00.
- R11: Any other command code (not 0x20, 0x30, 0xEC or 0xEF) sets the error bit, loads 0x04 into the error register and ends any active transfer.
- R12: Reads of the address and count offsets, and of undecoded offsets, return zero. `busRdData` updates one cycle after a read access and holds between reads.
- R13: Writes to the data ports or the feature offset have no effect on the transfer, the status or the returned data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one access per cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 16 | Read data, valid one cycle after a read access |
| fillWe | input | 1 | Byte-store fill write enable |
| fillAddr | input | PTR_W | Byte-store fill address |
| fillData | input | 8 | Byte-store fill data |

## Verification
Status, counter and address effects of an access are all in place after the clock edge that samples it. Read data appears on `busRdData` after that same edge. The bench drives every access on a falling edge and holds it for one cycle. It then samples `busRdData` at the next falling edge, which sits exactly one register stage after the access. Expected bytes come from a bench model of the pointer and the remaining length, fed by a fill pattern the bench computes. One check waits extra idle cycles to confirm that the read data holds between accesses.

// File: rtl/sptPkg.sv
package sptPkg;
  localparam int SECTOR_SHIFT = 9;
  localparam int LBA_W = 29;
  localparam int COUNT_W = 8 + SECTOR_SHIFT;
  localparam int LBA_FIELDS = 4;

  localparam logic [7:0] OFS_WORD     = 8'h20;
  localparam logic [7:0] OFS_BYTE     = 8'h21;
  localparam logic [7:0] OFS_ERR_FEAT = 8'h23;
  localparam logic [7:0] OFS_COUNT    = 8'h25;
  localparam logic [7:0] OFS_ADDR0    = 8'h27;
  localparam logic [7:0] OFS_ADDR1    = 8'h29;
  localparam logic [7:0] OFS_ADDR2    = 8'h2B;
  localparam logic [7:0] OFS_ADDR3    = 8'h2D;
  localparam logic [7:0] OFS_STAT_CMD = 8'h2F;

  localparam logic [7:0] OP_READ     = 8'h20;
  localparam logic [7:0] OP_WRITE    = 8'h30;
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;
  localparam logic [7:0] OP_SETFEAT  = 8'hEF;
  localparam logic [7:0] CODE_ABORT  = 8'h04;

  // Strobes from control to datapath, valid in the cycle of a bus access.
  typedef struct packed {
    logic       loadPtr;
    logic       takeByte;
    logic       takeHalf;
    logic       takeWord;
    logic       takeReg;
    logic [7:0] regVal;
  } dpCtl_t;

  function automatic logic [7:0] fieldOfs(input int idx);
    case (idx)
      0: return OFS_ADDR0;
      1: return OFS_ADDR1;
      2: return OFS_ADDR2;
      default: return OFS_ADDR3;
    endcase
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    return (idx == LBA_FIELDS - 1) ? 8'h1F : 8'hFF;
  endfunction
endpackage

// File: rtl/sptCtrl.sv
module sptCtrl
  import sptPkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [7:0]         busAddr,
  input  logic [7:0]         busWrData,
  output dpCtl_t             ctl,
  output logic [PTR_W-1:0]   startPtr,
  output logic [COUNT_W-1:0] remainOut,
  output logic               activeOut,
  output logic [LBA_W-1:0]   lbaOut,
  output logic               errOut,
  output logic [7:0]         errCodeOut
);
  localparam int FULL_W = LBA_W + SECTOR_SHIFT;

  logic [7:0]         lbaByte [LBA_FIELDS];
  logic [COUNT_W-1:0] remain;
  logic               xferActive;
  logic               errBit;
  logic [7:0]         errCode;

  logic wrEn, rdEn, rdByte, rdWord, moving, finish, cmdWr, countWr;
  logic [COUNT_W-1:0] nextRemain;
  logic [LBA_W-1:0]   lba;
  logic [FULL_W-1:0]  fullByteAddr;
  logic [7:0]         statusByte;

  assign wrEn    = busSel & busWe;
  assign rdEn    = busSel & ~busWe;
  assign rdByte  = rdEn && (busAddr == OFS_BYTE);
  assign rdWord  = rdEn && (busAddr == OFS_WORD);
  assign cmdWr   = wrEn && (busAddr == OFS_STAT_CMD);
  assign countWr = wrEn && (busAddr == OFS_COUNT);
  assign moving  = (rdByte | rdWord) & xferActive;

  always_comb begin
    if (rdWord) nextRemain = (remain >= COUNT_W'(2)) ? remain - COUNT_W'(2) : '0;
    else        nextRemain = remain - COUNT_W'(1);
  end
  assign finish = moving && (nextRemain == '0);

  // One register per address field; each write replaces its own field only.
  for (genvar gi = 0; gi < LBA_FIELDS; gi++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)                                 lbaByte[gi] <= '0;
      else if (finish)                           lbaByte[gi] <= '0;
      else if (wrEn && busAddr == fieldOfs(gi))  lbaByte[gi] <= busWrData & fieldMask(gi);
    end
  end

  assign lba = {lbaByte[3][4:0], lbaByte[2], lbaByte[1], lbaByte[0]};
  assign fullByteAddr = {lba, {SECTOR_SHIFT{1'b0}}};
  assign startPtr = fullByteAddr[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain     <= '0;
      xferActive <= 1'b0;
      errBit     <= 1'b0;
      errCode    <= '0;
    end else if (countWr) begin
      remain     <= {busWrData, {SECTOR_SHIFT{1'b0}}};
      xferActive <= 1'b0;
    end else if (cmdWr) begin
      case (busWrData)
        OP_READ: begin
          errBit     <= 1'b0;
          errCode    <= '0;
          xferActive <= (remain != '0);
        end
        OP_WRITE, OP_IDENTIFY, OP_SETFEAT: begin
          errBit     <= 1'b0;
          errCode    <= '0;
          xferActive <= 1'b0;
        end
        default: begin
          errBit     <= 1'b1;
          errCode    <= CODE_ABORT;
          xferActive <= 1'b0;
        end
      endcase
    end else if (moving) begin
      remain <= nextRemain;
      if (finish) xferActive <= 1'b0;
    end
  end

  assign statusByte = {1'b0, 3'b000, xferActive, 2'b00, errBit};

  always_comb begin
    ctl = '0;
    ctl.loadPtr = cmdWr && (busWrData == OP_READ) && (remain != '0);
    if (rdEn) begin
      case (busAddr)
        OFS_WORD: begin
          if (!xferActive)              ctl.takeReg  = 1'b1;
          else if (remain >= COUNT_W'(2)) ctl.takeWord = 1'b1;
          else                          ctl.takeHalf = 1'b1;
        end
        OFS_BYTE: begin
          if (xferActive) ctl.takeByte = 1'b1;
          else            ctl.takeReg  = 1'b1;
        end
        OFS_ERR_FEAT: begin
          ctl.takeReg = 1'b1;
          ctl.regVal  = errCode;
        end
        OFS_STAT_CMD: begin
          ctl.takeReg = 1'b1;
          ctl.regVal  = statusByte;
        end
        default: ctl.takeReg = 1'b1;
      endcase
    end
  end

  assign remainOut  = remain;
  assign activeOut  = xferActive;
  assign lbaOut     = lba;
  assign errOut     = errBit;
  assign errCodeOut = errCode;
endmodule

// File: rtl/sptData.sv
module sptData
  import sptPkg::*;
#(
  parameter int STORE_BYTES = 4096,
  parameter int PTR_W = $clog2(STORE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [PTR_W-1:0] startPtr,
  input  logic             fillWe,
  input  logic [PTR_W-1:0] fillAddr,
  input  logic [7:0]       fillData,
  output logic [15:0]      rdData
);
  logic [7:0]       store [STORE_BYTES];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrPlus1;

  assign ptrPlus1 = ptr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (fillWe) store[fillAddr] <= fillData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          ptr <= '0;
    else if (ctl.loadPtr)               ptr <= startPtr;
    else if (ctl.takeWord)              ptr <= ptr + PTR_W'(2);
    else if (ctl.takeByte || ctl.takeHalf) ptr <= ptrPlus1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             rdData <= '0;
    else if (ctl.takeWord)                 rdData <= {store[ptrPlus1], store[ptr]};
    else if (ctl.takeByte || ctl.takeHalf) rdData <= {8'h00, store[ptr]};
    else if (ctl.takeReg)                  rdData <= {8'h00, ctl.regVal};
  end
endmodule

// File: rtl/sectorPortTarget.sv
module sectorPortTarget
  import sptPkg::*;
#(
  parameter int STORE_BYTES = 4096,
  localparam int PTR_W = $clog2(STORE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWe,
  input  logic [7:0]       busAddr,
  input  logic [7:0]       busWrData,
  output logic [15:0]      busRdData,
  input  logic             fillWe,
  input  logic [PTR_W-1:0] fillAddr,
  input  logic [7:0]       fillData
);
  dpCtl_t             ctl;
  logic [PTR_W-1:0]   startPtr;
  logic [COUNT_W-1:0] remain;
  logic               xferActive;
  logic [LBA_W-1:0]   lba;
  logic               errBit;
  logic [7:0]         errCode;

  sptCtrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWrData(busWrData), .ctl(ctl), .startPtr(startPtr),
    .remainOut(remain), .activeOut(xferActive), .lbaOut(lba),
    .errOut(errBit), .errCodeOut(errCode)
  );

  sptData #(.STORE_BYTES(STORE_BYTES), .PTR_W(PTR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startPtr(startPtr),
    .fillWe(fillWe), .fillAddr(fillAddr), .fillData(fillData),
    .rdData(busRdData)
  );
endmodule

// File: rtl/sptChecker.sv
module sptChecker
  import sptPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWe,
  input logic [7:0]         busAddr,
  input logic [7:0]         busWrData,
  input logic [COUNT_W-1:0] remain,
  input logic               xferActive,
  input logic [LBA_W-1:0]   lba,
  input logic               errBit,
  input logic [7:0]         errCode
);
  logic rdByte, rdWord, knownOp, cmdWr;
  assign rdByte  = busSel && !busWe && busAddr == OFS_BYTE;
  assign rdWord  = busSel && !busWe && busAddr == OFS_WORD;
  assign cmdWr   = busSel && busWe && busAddr == OFS_STAT_CMD;
  assign knownOp = busWrData == OP_READ || busWrData == OP_WRITE ||
                   busWrData == OP_IDENTIFY || busWrData == OP_SETFEAT;

  p_active_has_bytes_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> remain != '0);

  p_byte_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdByte && xferActive) |=> remain == $past(remain) - COUNT_W'(1));

  p_word_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdWord && xferActive && remain >= COUNT_W'(2)) |=> remain == $past(remain) - COUNT_W'(2));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((rdByte || rdWord) && !xferActive) |=> $stable(remain));

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && ((rdByte && remain == COUNT_W'(1)) || (rdWord && remain <= COUNT_W'(2))))
      |=> (!xferActive && remain == '0 && lba == '0));

  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !knownOp) |=> (errBit && errCode == CODE_ABORT && !xferActive));

  p_good_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && knownOp && busWrData != OP_READ) |=> (!errBit && errCode == 8'h00 && !xferActive));
endmodule

bind sectorPortTarget sptChecker u_checker (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busWrData(busWrData), .remain(remain), .xferActive(xferActive), .lba(lba),
  .errBit(errBit), .errCode(errCode)
);

// File: tb/sectorPortTarget_test.sv
module sectorPortTarget_test;
  localparam int CLK_PERIOD  = 10;
  localparam int STORE_BYTES = 4096;
  localparam int PTR_W       = $clog2(STORE_BYTES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic [15:0] busRdData;
  logic fillWe = 1'b0;
  logic [PTR_W-1:0] fillAddr = '0;
  logic [7:0] fillData = '0;

  int checkCount = 0;
  int errCount = 0;
  bit doneFlag = 0;

  logic [7:0] mField [4];
  int   mRemain;
  bit   mActive;
  int   mPtr;
  bit   mErr;
  logic [7:0] mCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  sectorPortTarget #(.STORE_BYTES(STORE_BYTES)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .fillWe(fillWe),
    .fillAddr(fillAddr), .fillData(fillData)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 9) * 101 + 3) & 255);
  endfunction

  function automatic void modelWrite(input logic [7:0] a, input logic [7:0] d);
    longint lbaVal;
    case (a)
      8'h27: mField[0] = d;
      8'h29: mField[1] = d;
      8'h2B: mField[2] = d;
      8'h2D: mField[3] = d & 8'h1F;
      8'h25: begin mRemain = int'(d) * 512; mActive = 0; end
      8'h2F: begin
        if (d == 8'h20) begin
          mErr = 0; mCode = 8'h00;
          mActive = (mRemain != 0);
          lbaVal = {mField[3][4:0], mField[2], mField[1], mField[0]};
          if (mActive) mPtr = int'((lbaVal << 9) % STORE_BYTES);
        end else if (d == 8'h30 || d == 8'hEC || d == 8'hEF) begin
          mErr = 0; mCode = 8'h00; mActive = 0;
        end else begin
          mErr = 1; mCode = 8'h04; mActive = 0;
        end
      end
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] modelRead(input logic [7:0] a);
    logic [15:0] e;
    e = '0;
    case (a)
      8'h20, 8'h21: if (mActive) begin
        if (a == 8'h21 || mRemain < 2) begin
          e = {8'h00, pat(mPtr)};
          mPtr = (mPtr + 1) % STORE_BYTES;
          mRemain = mRemain - 1;
        end else begin
          e = {pat((mPtr + 1) % STORE_BYTES), pat(mPtr)};
          mPtr = (mPtr + 2) % STORE_BYTES;
          mRemain = mRemain - 2;
        end
        if (mRemain == 0) begin
          mActive = 0;
          for (int i = 0; i < 4; i++) mField[i] = '0;
        end
      end
      8'h23: e = {8'h00, mCode};
      8'h2F: e = {8'h00, 4'b0000, mActive, 2'b00, mErr};
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checkCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rdCheck(input logic [7:0] a, input string tag);
    logic [15:0] exp;
    exp = modelRead(a);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    check(tag, busRdData, exp);
  endtask

  task automatic setLba(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3);
    busWr(8'h27, b0); busWr(8'h29, b1); busWr(8'h2B, b2); busWr(8'h2D, b3);
  endtask

  task automatic finish_run();
    doneFlag = 1;
    $display("CHECKS %0d ERRORS %0d", checkCount, errCount);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!doneFlag) begin
      errCount++;
      $display("FAIL watchdog expired before the run ended");
      finish_run();
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) mField[i] = '0;
    mRemain = 0; mActive = 0; mPtr = 0; mErr = 0; mCode = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R12 reset read data", busRdData, 16'h0000);
    rdCheck(8'h2F, "R9 reset status");
    rdCheck(8'h23, "R1 reset error register");

    for (int a = 0; a < STORE_BYTES; a++) begin
      @(negedge clk);
      fillWe = 1'b1; fillAddr = PTR_W'(a); fillData = pat(a);
    end
    @(negedge clk);
    fillWe = 1'b0;

    // R2: field replace, head upper bits masked
    busWr(8'h27, 8'h05);
    setLba(8'h02, 8'h00, 8'h00, 8'hE0);
    busWr(8'h25, 8'h01);
    busWr(8'h2F, 8'h20);
    rdCheck(8'h2F, "R4 R9 status with data request");
    rdCheck(8'h20, "R5 R2 first word");
    rdCheck(8'h21, "R6 byte after word");
    busWr(8'h21, 8'hAA);
    busWr(8'h20, 8'h55);
    busWr(8'h23, 8'h77);
    rdCheck(8'h21, "R13 byte after data-port writes");
    rdCheck(8'h2F, "R13 status after ignored writes");
    rdCheck(8'h25, "R12 count offset reads zero");
    rdCheck(8'h27, "R12 address offset reads zero");
    rdCheck(8'h2A, "R12 undecoded offset reads zero");
    rdCheck(8'h20, "R5 word for hold test");
    held = busRdData;
    repeat (3) @(negedge clk);
    check("R12 read data holds", busRdData, held);

    // R11: unknown command aborts
    busWr(8'h2F, 8'h55);
    rdCheck(8'h2F, "R11 status error bit");
    rdCheck(8'h23, "R11 abort code");
    rdCheck(8'h20, "R8 word read after abort");
    rdCheck(8'h21, "R8 byte read after abort");

    // R10: accepted commands clear error, no transfer
    busWr(8'h2F, 8'hEC);
    rdCheck(8'h2F, "R10 status after identify");
    rdCheck(8'h23, "R10 error cleared");
    busWr(8'h2F, 8'h20);
    rdCheck(8'h2F, "R4 resumed remainder");
    busWr(8'h2F, 8'h30);
    rdCheck(8'h2F, "R10 write command ends transfer");
    busWr(8'h2F, 8'hEF);
    rdCheck(8'h2F, "R10 set-features status");

    // R4/R3: zero count starts nothing
    busWr(8'h25, 8'h00);
    busWr(8'h2F, 8'h20);
    rdCheck(8'h2F, "R4 zero count no request");
    rdCheck(8'h21, "R8 byte read with zero count");

    // R5 half word at the end, R7 clears address
    setLba(8'h03, 8'h00, 8'h00, 8'h00);
    busWr(8'h25, 8'h01);
    busWr(8'h2F, 8'h20);
    rdCheck(8'h21, "R6 odd start byte");
    for (int i = 0; i < 255; i++) rdCheck(8'h20, "R5 word stream");
    rdCheck(8'h20, "R5 last half word");
    rdCheck(8'h2F, "R7 status after end");
    busWr(8'h25, 8'h01);
    busWr(8'h2F, 8'h20);
    rdCheck(8'h20, "R7 address cleared to zero");
    busWr(8'h2F, 8'h30);

    // R8: idle reads do not consume the count; R3 exact length
    setLba(8'h01, 8'h00, 8'h00, 8'h00);
    busWr(8'h25, 8'h01);
    rdCheck(8'h20, "R8 idle word read");
    rdCheck(8'h21, "R8 idle byte read");
    busWr(8'h2F, 8'h20);
    for (int i = 0; i < 255; i++) rdCheck(8'h20, "R3 stream");
    rdCheck(8'h2F, "R3 request before last word");
    rdCheck(8'h20, "R3 last word");
    rdCheck(8'h2F, "R3 R7 request after exact length");

    // R2: modulo wrap of the store
    setLba(8'h0A, 8'h00, 8'h00, 8'h00);
    busWr(8'h25, 8'h01);
    busWr(8'h2F, 8'h20);
    rdCheck(8'h20, "R2 wrapped sector");
    busWr(8'h2F, 8'h30);

    // Random transfers
    for (int it = 0; it < 12; it++) begin
      setLba(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      busWr(8'h25, 8'(1 + $urandom % 2));
      busWr(8'h2F, 8'h20);
      rdCheck(8'h2F, "R4 random start");
      while (mActive) begin
        if ($urandom % 2) rdCheck(8'h20, "R5 random word");
        else              rdCheck(8'h21, "R6 random byte");
      end
      rdCheck(8'h2F, "R7 random end");
    end

    finish_run();
  end
endmodule